// File: doc/BRIEF.md
# Open-Page DRAM Bank Command Sequencer

This block accepts one read or write request at a time on a flat byte address and turns it into the DRAM command stream needed to serve it. The address is split into column, bank and row fields. For each bank the block remembers whether a row is latched in that bank's row buffer and which row it is. An access to the latched row goes straight to the data command. An access to a bank with nothing open first opens the row. An access to a bank holding a different row closes that row, opens the new one and then transfers the data.

A free-running refresh timer periodically takes over the command stream. It closes every open bank, one per cycle, and then issues a refresh, after which all banks count as closed. A per-bank counter of row openings is brought out so that a test environment can see how often each bank was activated. Commands go out one per cycle on a command/address bus toward a behavioural memory model. Read data from that model is returned with a valid pulse.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, `rd_valid` is 0 and every field of `act_count` is 0.
- R2: With `INTERLEAVE`=1 the column is the low `COL_BITS` address bits, the bank is the next `BANK_BITS` bits and the row is the top `ROW_BITS` bits. Rows that neighbour each other in one bank therefore lie `NUM_BANKS` × 2^`COL_BITS` bytes apart.
- R3: With `INTERLEAVE`=0 the column is the low `COL_BITS` bits, the row is the next `ROW_BITS` bits and the bank is the top `BANK_BITS` bits, so each bank covers one contiguous address range.
- R4: Command codes on `cmd_op` are 0 none, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE and 5 REFRESH. A request that hits the row open in its bank produces exactly one command, READ or WRITE, in the cycle after acceptance.
- R5: A request to a bank with no open row produces ACTIVATE (bank, row) and then READ or WRITE (bank, column) in the two cycles after acceptance.
- R6: A request to a bank holding a different row produces PRECHARGE of that bank, ACTIVATE of the new row and then READ or WRITE in the three cycles after acceptance.
- R7: `req_ready` is 1 only when no command sequence is in progress and no refresh is pending. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `cmd_valid` is 0 while the block is idle.
- R8: `rd_valid` is 1 in the cycle after each READ command and only then, with `rd_data` equal to the memory's returned data. WRITE commands carry the request's data on `cmd_wdata`.
- R9: A refresh becomes pending every `REF_INTERVAL` clock cycles after reset. A pending refresh is served before any waiting request.
- R10: Refresh issues one PRECHARGE per open bank in ascending bank order, one per cycle, and then REFRESH. After REFRESH no bank is open.
- R11: `act_count` bits [b·`CNT_W` +: `CNT_W`] count the ACTIVATE commands sent to bank b. Alternating accesses between two rows of one bank raise that count by one per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Flat byte address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request can be accepted |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BANK_BITS | Target bank |
| cmd_row | output | ROW_BITS | Row address (ACTIVATE) |
| cmd_col | output | COL_BITS | Column address (READ/WRITE) |
| cmd_wdata | output | DATA_W | Data for WRITE |
| dram_rdata | input | DATA_W | Data returned by the memory the cycle after READ |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| act_count | output | NUM_BANKS*CNT_W | Per-bank ACTIVATE counters |

## Verification
The bench targets the three access paths and how they interact with refresh. It looks for a hit that wrongly reopens its row, which would show up as an extra ACTIVATE and a jump in the bank's counter. It also looks for a conflict that skips the PRECHARGE, and for a refresh that starts while a bank is still open or leaves a stale open-row flag behind, which would make the next access to that row look like a hit. Requests are held waiting while the timer expires, so a design that lets traffic overtake the refresh shows up as a command out of order. Both address maps are decoded by the bench, so swapped bank and row fields show up as the wrong bank on ACTIVATE.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_XFER,
        ST_RPRE,
        ST_REF
    } seq_state_e;

    typedef enum logic [1:0] {
        PATH_HIT,
        PATH_EMPTY,
        PATH_CONFLICT
    } access_kind_e;

    function automatic access_kind_e classify(input logic bank_open, input logic same_row);
        if (!bank_open) return PATH_EMPTY;
        if (same_row)   return PATH_HIT;
        return PATH_CONFLICT;
    endfunction

endpackage

// File: rtl/dram_addr_map.sv
`timescale 1ns/1ps
module dram_addr_map #(
    parameter int ROW_BITS   = 4,
    parameter int BANK_BITS  = 2,
    parameter int COL_BITS   = 4,
    parameter int INTERLEAVE = 1,
    localparam int ADDR_W    = ROW_BITS + BANK_BITS + COL_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_BITS-1:0]  row,
    output logic [COL_BITS-1:0]  col
);
    assign col = addr[COL_BITS-1:0];

    generate
        if (INTERLEAVE != 0) begin : g_interleaved
            assign bank = addr[COL_BITS +: BANK_BITS];
            assign row  = addr[COL_BITS + BANK_BITS +: ROW_BITS];
        end else begin : g_contiguous
            assign row  = addr[COL_BITS +: ROW_BITS];
            assign bank = addr[COL_BITS + ROW_BITS +: BANK_BITS];
        end
    endgenerate
endmodule

// File: rtl/dram_bank_table.sv
`timescale 1ns/1ps
module dram_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_BITS  = 4,
    parameter int CNT_W     = 16,
    localparam int BANK_BITS = $clog2(NUM_BANKS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          act_fire,
    input  logic                          pre_fire,
    input  logic                          ref_fire,
    input  logic [BANK_BITS-1:0]          sel,
    input  logic [ROW_BITS-1:0]           row_in,
    output logic [NUM_BANKS-1:0]          open_vld,
    output logic [NUM_BANKS*ROW_BITS-1:0] open_rows,
    output logic [NUM_BANKS*CNT_W-1:0]    act_cnt
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic                vld_q;
        logic [ROW_BITS-1:0] row_q;
        logic [CNT_W-1:0]    cnt_q;
        logic                picked;

        assign picked = (sel == BANK_BITS'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                row_q <= '0;
                cnt_q <= '0;
            end else if (act_fire && picked) begin
                vld_q <= 1'b1;
                row_q <= row_in;
                cnt_q <= cnt_q + 1'b1;
            end else if ((pre_fire && picked) || ref_fire) begin
                vld_q <= 1'b0;
            end
        end

        assign open_vld[b]                       = vld_q;
        assign open_rows[b*ROW_BITS +: ROW_BITS] = row_q;
        assign act_cnt[b*CNT_W +: CNT_W]         = cnt_q;
    end
endmodule

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer #(
    parameter int REF_INTERVAL = 64,
    localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic served,
    output logic pending
);
    logic [TW-1:0] tick;
    logic          wrap;

    assign wrap = (tick == TW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick    <= '0;
            pending <= 1'b0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap)
                pending <= 1'b1;
            else if (served)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_bank_seq.sv
`timescale 1ns/1ps
module dram_bank_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int ROW_BITS     = 4,
    parameter int COL_BITS     = 4,
    parameter int DATA_W       = 8,
    parameter int INTERLEAVE   = 1,
    parameter int REF_INTERVAL = 64,
    parameter int CNT_W        = 16,
    localparam int BANK_BITS   = $clog2(NUM_BANKS),
    localparam int ADDR_W      = ROW_BITS + BANK_BITS + COL_BITS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic                       cmd_valid,
    output logic [2:0]                 cmd_op,
    output logic [BANK_BITS-1:0]       cmd_bank,
    output logic [ROW_BITS-1:0]        cmd_row,
    output logic [COL_BITS-1:0]        cmd_col,
    output logic [DATA_W-1:0]          cmd_wdata,
    input  logic [DATA_W-1:0]          dram_rdata,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_BANKS*CNT_W-1:0] act_count
);
    seq_state_e state, nxt;
    dram_cmd_e  op;
    access_kind_e kind;

    logic                 q_write;
    logic [BANK_BITS-1:0] q_bank;
    logic [ROW_BITS-1:0]  q_row;
    logic [COL_BITS-1:0]  q_col;
    logic [DATA_W-1:0]    q_wdata;

    logic [BANK_BITS-1:0] d_bank;
    logic [ROW_BITS-1:0]  d_row;
    logic [COL_BITS-1:0]  d_col;

    logic [NUM_BANKS-1:0]          open_vld;
    logic [NUM_BANKS*ROW_BITS-1:0] open_rows;
    logic [BANK_BITS-1:0]          low_bank;
    logic [NUM_BANKS-1:0]          low_oh;
    logic                          ref_pend;
    logic                          accept;

    dram_addr_map #(
        .ROW_BITS(ROW_BITS), .BANK_BITS(BANK_BITS),
        .COL_BITS(COL_BITS), .INTERLEAVE(INTERLEAVE)
    ) u_map (
        .addr(req_addr), .bank(d_bank), .row(d_row), .col(d_col)
    );

    dram_bank_table #(
        .NUM_BANKS(NUM_BANKS), .ROW_BITS(ROW_BITS), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst(rst),
        .act_fire(op == CMD_ACT), .pre_fire(op == CMD_PRE), .ref_fire(op == CMD_REF),
        .sel(cmd_bank), .row_in(q_row),
        .open_vld(open_vld), .open_rows(open_rows), .act_cnt(act_count)
    );

    dram_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst(rst), .served(op == CMD_REF), .pending(ref_pend)
    );

    assign req_ready = (state == ST_IDLE) && !ref_pend;
    assign accept    = req_valid && req_ready;
    assign kind      = classify(open_vld[d_bank],
                                open_rows[d_bank*ROW_BITS +: ROW_BITS] == d_row);

    // lowest-numbered open bank, closed first during refresh
    always_comb begin
        low_bank = '0;
        low_oh   = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (open_vld[b]) begin
                low_bank = BANK_BITS'(b);
                low_oh   = NUM_BANKS'(1) << b;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend)
                    nxt = (|open_vld) ? ST_RPRE : ST_REF;
                else if (accept) begin
                    unique case (kind)
                        PATH_HIT:      nxt = ST_XFER;
                        PATH_EMPTY:    nxt = ST_ACT;
                        PATH_CONFLICT: nxt = ST_PRE;
                        default:       nxt = ST_ACT;
                    endcase
                end
            end
            ST_PRE:  nxt = ST_ACT;
            ST_ACT:  nxt = ST_XFER;
            ST_XFER: nxt = ST_IDLE;
            ST_RPRE: nxt = ((open_vld & ~low_oh) == '0) ? ST_REF : ST_RPRE;
            ST_REF:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        op       = CMD_NOP;
        cmd_bank = q_bank;
        cmd_row  = q_row;
        cmd_col  = q_col;
        unique case (state)
            ST_PRE:  op = CMD_PRE;
            ST_ACT:  op = CMD_ACT;
            ST_XFER: op = q_write ? CMD_WR : CMD_RD;
            ST_RPRE: begin
                op       = CMD_PRE;
                cmd_bank = low_bank;
            end
            ST_REF:  op = CMD_REF;
            default: op = CMD_NOP;
        endcase
    end

    assign cmd_op    = op;
    assign cmd_valid = (state != ST_IDLE);
    assign cmd_wdata = q_wdata;
    assign rd_data   = dram_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            q_write  <= 1'b0;
            q_bank   <= '0;
            q_row    <= '0;
            q_col    <= '0;
            q_wdata  <= '0;
            rd_valid <= 1'b0;
        end else begin
            state    <= nxt;
            rd_valid <= (op == CMD_RD);
            if (accept) begin
                q_write <= req_write;
                q_bank  <= d_bank;
                q_row   <= d_row;
                q_col   <= d_col;
                q_wdata <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/dram_bank_seq_chk.sv
`timescale 1ns/1ps
module dram_bank_seq_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_BITS  = 4,
    parameter int BANK_BITS = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cmd_valid,
    input logic [2:0]                    cmd_op,
    input logic [BANK_BITS-1:0]          cmd_bank,
    input logic [ROW_BITS-1:0]           cmd_row,
    input logic                          rd_valid,
    input logic [NUM_BANKS-1:0]          open_vld,
    input logic [NUM_BANKS*ROW_BITS-1:0] open_rows
);
    // R5
    act_on_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1) |-> !open_vld[cmd_bank]);

    // R6
    pre_on_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd4) |-> open_vld[cmd_bank]);

    // R4
    xfer_row_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)) |->
            (open_vld[cmd_bank] && open_rows[cmd_bank*ROW_BITS +: ROW_BITS] == cmd_row));

    // R10
    refresh_all_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd5) |-> (open_vld == '0));

    // R10
    refresh_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd5) |=> (open_vld == '0));

    // R8
    read_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd2) |=> rd_valid);

    // R8
    read_pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_valid && cmd_op == 3'd2));
endmodule

bind dram_bank_seq dram_bank_seq_chk #(
    .NUM_BANKS(NUM_BANKS), .ROW_BITS(ROW_BITS), .BANK_BITS(BANK_BITS)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .rd_valid(rd_valid),
    .open_vld(open_vld), .open_rows(open_rows)
);

// File: tb/tb_dram_bank_seq.sv
`timescale 1ns/1ps
module tb_dram_bank_seq;
    localparam int NB = 4;
    localparam int RB = 4;
    localparam int CB = 4;
    localparam int DW = 8;
    localparam int RI = 64;
    localparam int CW = 16;
    localparam int BB = 2;
    localparam int AW = RB + BB + CB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, cmd_valid, rd_valid;
    logic [2:0]    cmd_op;
    logic [BB-1:0] cmd_bank;
    logic [RB-1:0] cmd_row;
    logic [CB-1:0] cmd_col;
    logic [DW-1:0] cmd_wdata, rd_data;
    logic [DW-1:0] dram_rdata = '0;
    logic [NB*CW-1:0] act_count;

    dram_bank_seq #(.NUM_BANKS(NB), .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW),
                    .INTERLEAVE(1), .REF_INTERVAL(RI), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .dram_rdata(dram_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .act_count(act_count));

    // second instance with the contiguous map
    logic          f_valid = 1'b0;
    logic [AW-1:0] f_addr = '0;
    logic          f_ready, f_cmd_valid, f_rd_valid;
    logic [2:0]    f_cmd_op;
    logic [BB-1:0] f_cmd_bank;
    logic [RB-1:0] f_cmd_row;
    logic [CB-1:0] f_cmd_col;
    logic [DW-1:0] f_cmd_wdata, f_rd_data;
    logic [NB*CW-1:0] f_act;

    dram_bank_seq #(.NUM_BANKS(NB), .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW),
                    .INTERLEAVE(0), .REF_INTERVAL(100000), .CNT_W(CW)) dut_flat (
        .clk(clk), .rst(rst), .req_valid(f_valid), .req_write(1'b0),
        .req_addr(f_addr), .req_wdata(8'h00), .req_ready(f_ready),
        .cmd_valid(f_cmd_valid), .cmd_op(f_cmd_op), .cmd_bank(f_cmd_bank), .cmd_row(f_cmd_row),
        .cmd_col(f_cmd_col), .cmd_wdata(f_cmd_wdata), .dram_rdata(8'h00),
        .rd_valid(f_rd_valid), .rd_data(f_rd_data), .act_count(f_act));

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] seed_byte(input int b, input int r, input int c);
        return 8'((b * 7 + r * 13 + c * 29 + 5) & 255);
    endfunction

    // ---------------- behavioural memory stub ----------------
    logic [7:0] smem [0:1023];
    int         s_row [NB];

    initial begin
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++)
                    smem[b*256 + r*16 + c] = seed_byte(b, r, c);
        for (int b = 0; b < NB; b++) s_row[b] = 0;
    end

    always @(posedge clk) begin
        if (!rst && cmd_valid) begin
            case (cmd_op)
                3'd1: s_row[cmd_bank] = int'(cmd_row);
                3'd3: smem[int'(cmd_bank)*256 + s_row[cmd_bank]*16 + int'(cmd_col)] = cmd_wdata;
                3'd2: dram_rdata <= smem[int'(cmd_bank)*256 + s_row[cmd_bank]*16 + int'(cmd_col)];
                default: ;
            endcase
        end
    end

    // ---------------- reference model ----------------
    typedef struct {
        int op; int bank; int row; int col; int wdata; int addr;
    } exp_cmd_t;

    exp_cmd_t   q[$];
    string      tagq[$];
    exp_cmd_t   e;
    string      etag;
    int         m_open [NB];
    int         m_row  [NB];
    int         m_act  [NB];
    bit         m_pend;
    int         m_cnt;
    bit         m_rdv;
    logic [7:0] m_rdd;
    logic [7:0] m_mem [0:1023];

    // R2: bench decode of the interleaved map
    function automatic int a_col(input int a);  return a & 15;        endfunction
    function automatic int a_bank(input int a); return (a >> 4) & 3;  endfunction
    function automatic int a_row(input int a);  return (a >> 6) & 15; endfunction

    initial begin
        for (int a = 0; a < 1024; a++) m_mem[a] = seed_byte(a_bank(a), a_row(a), a_col(a));
    end

    function automatic void push(input int op, input int b, input int r, input int c,
                                 input int w, input int a, input string t);
        exp_cmd_t x;
        x.op = op; x.bank = b; x.row = r; x.col = c; x.wdata = w; x.addr = a;
        q.push_back(x);
        tagq.push_back(t);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); tagq.delete();
            m_pend = 1'b0; m_cnt = 0; m_rdv = 1'b0; m_rdd = '0;
            for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_act[b] = 0; end
        end else begin
            m_rdv = 1'b0;
            if (q.size() > 0) begin
                e    = q.pop_front();
                etag = tagq.pop_front();
                case (e.op)
                    1: begin m_open[e.bank] = 1; m_row[e.bank] = e.row; m_act[e.bank]++; end
                    4: m_open[e.bank] = 0;
                    5: begin for (int b = 0; b < NB; b++) m_open[b] = 0; m_pend = 1'b0; end
                    3: m_mem[e.addr] = 8'(e.wdata);
                    2: begin m_rdv = 1'b1; m_rdd = m_mem[e.addr]; end
                    default: ;
                endcase
            end else if (m_pend) begin
                // R10: close open banks lowest first, then refresh
                for (int b = 0; b < NB; b++)
                    if (m_open[b] != 0) push(4, b, 0, 0, 0, 0, "R10");
                push(5, 0, 0, 0, 0, 0, "R10");
            end else if (req_valid) begin
                int a, b, r, c, o;
                a = int'(req_addr); b = a_bank(a); r = a_row(a); c = a_col(a);
                o = req_write ? 3 : 2;
                if (m_open[b] != 0 && m_row[b] == r) begin
                    push(o, b, r, c, int'(req_wdata), a, "R4");
                end else if (m_open[b] != 0) begin
                    push(4, b, 0, 0, 0, 0, "R6");
                    push(1, b, r, 0, 0, 0, "R6");
                    push(o, b, r, c, int'(req_wdata), a, "R6");
                end else begin
                    push(1, b, r, 0, 0, 0, "R5");
                    push(o, b, r, c, int'(req_wdata), a, "R5");
                end
            end
            // R9: refresh interval
            if (m_cnt == RI - 1) begin m_cnt = 0; m_pend = 1'b1; end
            else m_cnt++;
        end
    end

    // ---------------- per-cycle comparison ----------------
    int nref  = 0;
    int ncyc  = 0;
    logic [7:0] last_rd = '0;

    always @(negedge clk) begin
        if (started && !done && !rst) begin
            ncyc++;
            chk(req_ready == ((q.size() == 0) && !m_pend), m_pend ? "R9" : "R7",
                int'(req_ready), int'((q.size() == 0) && !m_pend));
            if (q.size() == 0) begin
                chk(cmd_valid == 1'b0, "R7", int'(cmd_valid), 0);
            end else begin
                chk(cmd_valid == 1'b1 && int'(cmd_op) == q[0].op, tagq[0], int'(cmd_op), q[0].op);
                if (q[0].op != 5)
                    chk(int'(cmd_bank) == q[0].bank, "R2", int'(cmd_bank), q[0].bank);
                if (q[0].op == 1)
                    chk(int'(cmd_row) == q[0].row, "R2", int'(cmd_row), q[0].row);
                if (q[0].op == 2 || q[0].op == 3)
                    chk(int'(cmd_col) == q[0].col, "R2", int'(cmd_col), q[0].col);
                if (q[0].op == 3)
                    chk(int'(cmd_wdata) == (q[0].wdata & 255), "R8", int'(cmd_wdata), q[0].wdata & 255);
            end
            chk(rd_valid == m_rdv, "R8", int'(rd_valid), int'(m_rdv));
            if (m_rdv) chk(rd_data == m_rdd, "R8", int'(rd_data), int'(m_rdd));
            for (int b = 0; b < NB; b++)
                chk(int'(act_count[b*CW +: CW]) == m_act[b], "R11",
                    int'(act_count[b*CW +: CW]), m_act[b]);
            if (cmd_valid && cmd_op == 3'd5) nref++;
            if (rd_valid) last_rd = rd_data;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input int a, input int d);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = DW'(d);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int mk(input int b, input int r, input int c);
        return (r << 6) | (b << 4) | c;
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        int a0, seed, w, a;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", int'(cmd_valid), 0);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        chk(act_count == '0, "R1", int'(act_count[CW-1:0]), 0);
        started = 1'b1;

        // R3: contiguous map, bank 2 row 5 column 3
        f_valid = 1'b1; f_addr = AW'((2 << 8) | (5 << 4) | 3);
        while (!f_ready) @(negedge clk);
        @(negedge clk);
        f_valid = 1'b0;
        chk(f_cmd_valid && f_cmd_op == 3'd1, "R3", int'(f_cmd_op), 1);
        chk(f_cmd_bank == 2'd2, "R3", int'(f_cmd_bank), 2);
        chk(f_cmd_row == 4'd5, "R3", int'(f_cmd_row), 5);
        @(negedge clk);
        chk(f_cmd_op == 3'd2 && f_cmd_col == 4'd3, "R3", int'(f_cmd_col), 3);

        // R5, R4, R6 directed paths with read-back (R8)
        issue(1'b1, mk(0, 1, 2), 8'h3C);
        issue(1'b0, mk(0, 1, 2), 0);
        wait_idle();
        chk(last_rd == 8'h3C, "R8", int'(last_rd), 8'h3C);
        issue(1'b0, mk(0, 2, 7), 0);
        issue(1'b1, mk(0, 2, 7), 8'h81);
        issue(1'b0, mk(0, 2, 7), 0);
        wait_idle();
        chk(last_rd == 8'h81, "R8", int'(last_rd), 8'h81);

        // R11: alternating two rows of bank 1
        a0 = int'(act_count[1*CW +: CW]);
        for (int k = 0; k < 6; k++) issue(1'b0, mk(1, (k % 2 == 0) ? 3 : 7, k), 0);
        wait_idle();
        chk(int'(act_count[1*CW +: CW]) - a0 == 6, "R11", int'(act_count[1*CW +: CW]) - a0, 6);

        // mixed traffic across banks, requests held across refresh (R9, R10)
        seed = 1;
        for (int k = 0; k < 220; k++) begin
            seed = seed * 1103515245 + 12345;
            w = (seed >>> 16) & 1;
            a = mk((seed >>> 8) & 3, (seed >>> 4) & 3, (seed >>> 12) & 15);
            issue(w[0], a, (seed >>> 20) & 255);
        end
        wait_idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        // R9: refresh count matches elapsed time
        chk(nref >= ncyc / RI - 1 && nref <= ncyc / RI + 1, "R9", nref, ncyc / RI);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule